// File: doc/BRIEF.md
# Add and Reverse-Subtract Integer Unit

This unit performs the integer add, reverse-subtract and compare operations of a small RISC core. Each issued instruction presents two register operands, a 16-bit immediate field, a 6-bit major opcode, an 11-bit function field and the current carry flag. Within the same cycle the unit returns the arithmetic result, the value the carry flag should take next, and a strobe that says whether the carry flag is written.

The low four opcode bits of the arithmetic family each switch one behaviour. One selects subtraction, which is always reversed (B minus A). One feeds the carry flag in as the carry input. One keeps the carry flag unchanged. One replaces operand B with an immediate. A separate prefix opcode stores a 16-bit upper half. The next issued instruction uses that half as the upper part of its immediate and then discards it. Compare is the keep-carry reverse subtract with a special function code. It returns B minus A with the most significant bit replaced by the true ordering of the two operands.

The prefix holding register is the only state. Everything else is combinational from the inputs of the current cycle.

Top module: `addsub_alu`

## Requirements
- R1: Opcode 000000 returns A + B on `result`, raises `carry_we` and gives the carry out of bit 31 on `carry_next`.
- R2: Opcode 000001 returns B + ~A + 1, raises `carry_we` and gives its carry out, which is 1 exactly when B >= A unsigned.
- R3: In opcodes whose value bit 1 is set (weight 2), the carry input is `carry_flag` instead of 0 for add or 1 for subtract.
- R4: In opcodes whose value bit 2 is set (weight 4), `carry_we` is 0 and `carry_next` equals `carry_flag`. The sum is unaffected.
- R5: In opcodes whose value bit 3 is set (weight 8), the immediate replaces B. Without a pending prefix the 16-bit field is sign-extended to 32 bits.
- R6: Opcode 000101 with function 00000000001 returns B − A with bit 31 set to 1 exactly when B < A as signed numbers. The carry flag is not written.
- R7: Opcode 000101 with function 00000000011 does the same as R6, with the ordering taken as unsigned.
- R8: An issued prefix opcode 101100 stores its immediate field. The next issued instruction uses {stored, field} as its 32-bit immediate. The prefix itself returns 0 and does not write the carry.
- R9: A stored prefix applies to exactly one issued instruction. Cycles with `issue` low keep it. A later prefix replaces it.
- R10: Reset clears any stored prefix.
- R11: Opcodes whose top two bits are not 00 return 0 and never write the carry. `carry_we` is 0 in every cycle without `issue`.
- R12: The function field only matters for opcode 000101 with codes 1 or 3. Any other function code, or any other opcode, gives the plain arithmetic result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| opcode | input | 6 | Major opcode, instruction bits 0..5 (MSB first) |
| func | input | 11 | Function field, instruction bits 21..31 |
| op_a | input | 32 | Register operand A |
| op_b | input | 32 | Register operand B |
| imm | input | 16 | Immediate field |
| carry_flag | input | 1 | Current carry flag |
| result | output | 32 | Arithmetic or compare result |
| carry_next | output | 1 | Next carry flag value |
| carry_we | output | 1 | Carry flag write strobe |

## Verification
The prefix holding register is the only state. If it is wrong, it shows on `result` of the very next issued immediate-form instruction, as a wrong upper half or as a missing sign extension. The sweeps therefore run an immediate-form operation after each prefix, after idle gaps, after foreign opcodes and after reset. All other logic is combinational, so a decode or adder fault shows on `result`, `carry_next` or `carry_we` in the same cycle. An all-pairs sweep over boundary operands covers every family opcode with both carry values.

// File: rtl/addsub_alu_pkg.sv
package addsub_alu_pkg;

  // Opcode values that carry meaning on their own
  localparam logic [5:0]  OPC_PREFIX    = 6'b101100;
  localparam logic [5:0]  OPC_RSUB_KEEP = 6'b000101;
  localparam logic [1:0]  FAMILY_TOP    = 2'b00;

  // Function codes that turn the keep-carry reverse subtract into a compare
  localparam logic [10:0] FN_CMP_SIGNED   = 11'd1;
  localparam logic [10:0] FN_CMP_UNSIGNED = 11'd3;

  // Bit positions inside the opcode vector ([5] is instruction bit 0)
  localparam int OPB_SUB  = 0;
  localparam int OPB_CIN  = 1;
  localparam int OPB_KEEP = 2;
  localparam int OPB_IMM  = 3;

  typedef struct packed {
    logic family;
    logic subtract;
    logic use_carry;
    logic keep;
    logic imm_form;
    logic compare;
    logic cmp_signed;
    logic prefix;
  } op_dec_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_alu_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [10:0] func,
  output op_dec_t     dec
);

  logic is_cmp_s;
  logic is_cmp_u;

  always_comb begin
    is_cmp_s       = (func == FN_CMP_SIGNED);
    is_cmp_u       = (func == FN_CMP_UNSIGNED);
    dec            = '0;
    dec.family     = (opcode[5:4] == FAMILY_TOP);
    dec.subtract   = dec.family & opcode[OPB_SUB];
    dec.use_carry  = dec.family & opcode[OPB_CIN];
    dec.keep       = dec.family & opcode[OPB_KEEP];
    dec.imm_form   = dec.family & opcode[OPB_IMM];
    dec.compare    = (opcode == OPC_RSUB_KEEP) & (is_cmp_s | is_cmp_u);
    dec.cmp_signed = is_cmp_s;
    dec.prefix     = (opcode == OPC_PREFIX);
  end

endmodule

// File: rtl/addsub_imm_hold.sv
module addsub_imm_hold #(
  parameter  int IMM_W = 16,
  localparam int W     = 2 * IMM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             is_prefix,
  input  logic [IMM_W-1:0] imm_field,
  output logic [W-1:0]     imm_value
);

  logic             hold_v_q, hold_v_d;
  logic [IMM_W-1:0] hold_q, hold_d;
  logic             valid_en;
  logic             data_en;

  // next-state
  always_comb begin
    valid_en = issue;
    data_en  = issue & is_prefix;
    hold_v_d = is_prefix;
    hold_d   = imm_field;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      if (valid_en) hold_v_q <= hold_v_d;
      if (data_en)  hold_q   <= hold_d;
    end
  end

  always_comb begin
    if (hold_v_q) imm_value = {hold_q, imm_field};
    else          imm_value = {{IMM_W{imm_field[IMM_W-1]}}, imm_field};
  end

  // R8
  prefix_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_prefix) |=> (hold_v_q && hold_q == $past(imm_field)));

  // R9
  prefix_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !is_prefix) |=> !hold_v_q);

  // R9
  prefix_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue) |=> $stable(hold_v_q));

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter  int W     = 32,
  parameter  int SEG_W = 8,
  localparam int NSEG  = W / SEG_W
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         cin,
  input  logic         invert_a,
  input  logic         force_msb,
  input  logic         cmp_signed,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W-1:0]  x;
  logic [W-1:0]  raw;
  logic [NSEG:0] chain;
  logic          ovf;
  logic          lt_s;
  logic          lt_u;
  logic          top_bit;

  assign x        = invert_a ? ~opnd_a : opnd_a;
  assign chain[0] = cin;

  // carry chain built from equal segments; W is a multiple of SEG_W
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W:0] part;
    assign part = {1'b0, x[g*SEG_W +: SEG_W]}
                + {1'b0, opnd_b[g*SEG_W +: SEG_W]}
                + {{SEG_W{1'b0}}, chain[g]};
    assign raw[g*SEG_W +: SEG_W] = part[SEG_W-1:0];
    assign chain[g+1]            = part[SEG_W];
  end

  assign cout = chain[NSEG];

  // ordering from the subtractor: signed uses overflow, unsigned uses borrow
  always_comb begin
    ovf     = (x[W-1] == opnd_b[W-1]) && (raw[W-1] != opnd_b[W-1]);
    lt_s    = raw[W-1] ^ ovf;
    lt_u    = ~cout;
    top_bit = force_msb ? (cmp_signed ? lt_s : lt_u) : raw[W-1];
    sum     = {top_bit, raw[W-2:0]};
  end

endmodule

// File: rtl/addsub_alu.sv
module addsub_alu
  import addsub_alu_pkg::*;
#(
  parameter  int IMM_W = 16,
  parameter  int SEG_W = 8,
  localparam int W     = 2 * IMM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [5:0]       opcode,
  input  logic [10:0]      func,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             carry_flag,
  output logic [W-1:0]     result,
  output logic             carry_next,
  output logic             carry_we
);

  op_dec_t      dec;
  logic [W-1:0] imm_value;
  logic [W-1:0] b_sel;
  logic         cin;
  logic [W-1:0] core_sum;
  logic         core_cout;

  addsub_decode u_decode (
    .opcode (opcode),
    .func   (func),
    .dec    (dec)
  );

  addsub_imm_hold #(.IMM_W(IMM_W)) u_imm_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .is_prefix (dec.prefix),
    .imm_field (imm),
    .imm_value (imm_value)
  );

  always_comb begin
    b_sel = dec.imm_form ? imm_value : op_b;
    cin   = dec.use_carry ? carry_flag : dec.subtract;
  end

  addsub_core #(.W(W), .SEG_W(SEG_W)) u_core (
    .opnd_a     (op_a),
    .opnd_b     (b_sel),
    .cin        (cin),
    .invert_a   (dec.subtract),
    .force_msb  (dec.compare),
    .cmp_signed (dec.cmp_signed),
    .sum        (core_sum),
    .cout       (core_cout)
  );

  always_comb begin
    carry_we   = issue & dec.family & ~dec.keep;
    carry_next = carry_we ? core_cout : carry_flag;
    result     = dec.family ? core_sum : '0;
  end

  // R1
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == 6'b000000) |->
      ({carry_next, result} == ({1'b0, op_a} + {1'b0, op_b})));

  // R4
  keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode[5:4] == 2'b00 && opcode[2]) |->
      (!carry_we && carry_next == carry_flag));

  // R6
  cmp_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == 6'b000101 && func == 11'd1) |->
      (result[W-1] == ($signed(op_b) < $signed(op_a))));

  // R7
  cmp_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == 6'b000101 && func == 11'd3) |->
      (result[W-1] == (op_b < op_a)));

  // R11
  foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode[5:4] != 2'b00 || !issue) |-> !carry_we);

endmodule

// File: tb/addsub_alu_bench.sv
module addsub_alu_bench;

  localparam logic [5:0] PFX = 6'b101100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [5:0]  opcode;
  logic [10:0] func;
  logic [31:0] op_a, op_b;
  logic [15:0] imm;
  logic        carry_flag;
  logic [31:0] result;
  logic        carry_next;
  logic        carry_we;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit        pend_v   = 1'b0;
  logic [15:0] pend_val = '0;

  logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                            32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678,
                            32'hFFFF_0000, 32'h0000_FFFF};

  always #10 clk = ~clk;

  addsub_alu u_addsub_alu (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .func(func),
    .op_a(op_a), .op_b(op_b), .imm(imm), .carry_flag(carry_flag),
    .result(result), .carry_next(carry_next), .carry_we(carry_we)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [33:0] expect_op(logic [5:0] op, logic [10:0] fn,
      logic [31:0] a, logic [31:0] b, logic [31:0] immx, logic c);
    logic [32:0] t;
    logic [31:0] y, r;
    logic cin, we;
    if (op[5:4] != 2'b00) return {1'b0, c, 32'h0};
    y   = op[3] ? immx : b;
    cin = op[1] ? c : op[0];
    if (op[0]) t = {1'b0, y} + {1'b0, ~a} + {32'h0, cin};
    else       t = {1'b0, y} + {1'b0, a}  + {32'h0, cin};
    r = t[31:0];
    if (op == 6'b000101 && fn == 11'd1) r[31] = ($signed(b) < $signed(a));
    if (op == 6'b000101 && fn == 11'd3) r[31] = (b < a);
    we = !op[2];
    return {we, we ? t[32] : c, r};
  endfunction

  function automatic string auto_tag(logic [5:0] op, logic [10:0] fn);
    if (op == PFX)                  return "R8";
    if (op[5:4] != 2'b00)           return "R11";
    if (op == 6'b000101 && fn == 11'd1) return "R6";
    if (op == 6'b000101 && fn == 11'd3) return "R7";
    if (op[3])                      return "R5";
    if (op[2])                      return "R4";
    if (op[1])                      return "R3";
    if (op[0])                      return "R2";
    return "R1";
  endfunction

  task automatic do_op(input logic [5:0] op, input logic [10:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic c, input string tag);
    logic [31:0] immx;
    logic [33:0] e;
    string t;
    @(negedge clk);
    issue = 1'b1; opcode = op; func = fn; op_a = a; op_b = b; imm = im;
    carry_flag = c;
    immx = pend_v ? {pend_val, im} : {{16{im[15]}}, im};
    e = expect_op(op, fn, a, b, immx, c);
    t = (tag != "") ? tag : auto_tag(op, fn);
    #2;
    check(result == e[31:0], t, "result", result, e[31:0]);
    check(carry_we == e[33], t, "carry_we", {31'h0, carry_we}, {31'h0, e[33]});
    check(carry_next == e[32], t, "carry_next", {31'h0, carry_next}, {31'h0, e[32]});
    @(posedge clk);
    if (op == PFX) pend_val = im;
    pend_v = (op == PFX);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      issue = 1'b0; opcode = 6'b000000;
      #2;
      check(carry_we == 1'b0, "R11", "idle carry_we", {31'h0, carry_we}, 32'h0);
      @(posedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue = 1'b0;
    pend_v = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; issue = 1'b0; opcode = '0; func = '0; op_a = '0; op_b = '0;
    imm = '0; carry_flag = 1'b0;
    do_reset();
    // reset state: no prefix pending, no carry write without issue (R10, R11)
    opcode = 6'b001000; imm = 16'h8000; op_a = 32'h0;
    #2;
    check(result == 32'hFFFF_8000, "R10", "reset imm", result, 32'hFFFF_8000);
    check(carry_we == 1'b0, "R11", "reset carry_we", {31'h0, carry_we}, 32'h0);

    // all family opcodes against boundary operand pairs, both carries
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++)
            do_op(6'(op), 11'd0, vals[i], vals[j],
                  vals[j][15:0] ^ vals[i][31:16], 1'(c), "");

    // compares and function codes that must be ignored (R6, R7, R12)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        do_op(6'b000101, 11'd1, vals[i], vals[j], 16'h0, 1'b1, "R6");
        do_op(6'b000101, 11'd3, vals[i], vals[j], 16'h0, 1'b0, "R7");
        do_op(6'b000101, 11'd2, vals[i], vals[j], 16'h0, 1'b1, "R12");
        do_op(6'b000100, 11'd1, vals[i], vals[j], 16'h0, 1'b0, "R12");
        do_op(6'b000001, 11'd3, vals[i], vals[j], 16'h0, 1'b0, "R12");
      end

    // foreign opcodes (R11)
    do_op(6'b100000, 11'd0, 32'h5, 32'h7, 16'h1, 1'b1, "R11");
    do_op(6'b010000, 11'd0, 32'h5, 32'h7, 16'h1, 1'b0, "R11");

    // prefix with every immediate-form opcode (R8)
    for (int k = 8; k < 16; k++) begin
      do_op(PFX, 11'd0, 32'h0, 32'h0, vals[k-8][31:16] ^ 16'hA5C3, 1'b0, "R8");
      do_op(6'(k), 11'd0, vals[k-8], 32'h0, 16'h8001, 1'b1, "R8");
    end
    do_op(PFX, 11'd0, 32'h0, 32'h0, 16'hABCD, 1'b0, "R8");
    do_op(6'b001000, 11'd0, 32'h1, 32'h0, 16'h0002, 1'b0, "R8");

    // idle gap keeps the prefix, it then applies once (R9)
    do_op(PFX, 11'd0, 32'h0, 32'h0, 16'h1234, 1'b0, "R9");
    idle(3);
    do_op(6'b001100, 11'd0, 32'h0, 32'h0, 16'hFFFF, 1'b0, "R9");
    do_op(6'b001100, 11'd0, 32'h0, 32'h0, 16'hFFFF, 1'b0, "R9");
    // second prefix replaces the first
    do_op(PFX, 11'd0, 32'h0, 32'h0, 16'h1111, 1'b0, "R9");
    do_op(PFX, 11'd0, 32'h0, 32'h0, 16'h2222, 1'b0, "R9");
    do_op(6'b001000, 11'd0, 32'h3, 32'h0, 16'h8000, 1'b0, "R9");
    // a foreign instruction consumes the prefix
    do_op(PFX, 11'd0, 32'h0, 32'h0, 16'h7777, 1'b0, "R9");
    do_op(6'b100000, 11'd0, 32'h0, 32'h0, 16'h0, 1'b0, "R9");
    do_op(6'b001000, 11'd0, 32'h0, 32'h0, 16'h9000, 1'b0, "R9");

    // reset clears a pending prefix (R10)
    do_op(PFX, 11'd0, 32'h0, 32'h0, 16'h5555, 1'b0, "R10");
    do_reset();
    do_op(6'b001000, 11'd0, 32'h0, 32'h0, 16'h8001, 1'b0, "R10");

    idle(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule